// File: doc/BRIEF.md
# Serial Flash Quad-Mode Enable Sequencer

This block brings a serial NOR flash into quad I/O mode without software help. Once reset is released it launches a fixed command sequence on its own, and it runs the sequence again whenever it sees a start pulse while idle. It has one single-lane SPI master port: chip select, serial clock, a data output and a data input. The sequence has five steps. It reads the flash's volatile configuration byte, then issues write enable. It writes the byte back with the quad-enable bit cleared, since that bit is active-low. It polls the status byte until the write-in-progress flag drops. Finally it reads the configuration byte again to confirm that the quad bit really is clear.

The outcome is reported on three level outputs: busy, done and error. A 2-bit code says why the sequence failed. A status poll that never sees the device become ready ends the run with a timeout. A confirming read that still shows the quad bit set ends the run with a verify failure. Only single-lane command and register traffic is covered. Array reads, programs and erases belong to other logic.

Top module: `flash_quad_enabler`

## Requirements
- R1: While reset is held, cs_n is 1, sclk is 0 and busy, done, err and err_code are all 0. The sequence then starts by itself after reset is released, with no start pulse.
- R2: Each run issues its frames in this order. First 0x65 followed by one read byte. Then 0x06 alone. Then 0x61 followed by one written byte. Then one or more 0x05 frames, each followed by one read byte. Last, 0x65 followed by one read byte, unless the run timed out.
- R3: The byte sent after 0x61 equals the byte read in the first 0x65 frame with bit 7 forced to 0. Bits 6..0 are unchanged.
- R4: SPI mode 0 is used. sclk is 0 whenever cs_n changes, data is sent MSB first, and the rising edges of sclk within a frame are exactly DIV system clocks apart.
- R5: Between two frames cs_n stays high for at least 2 system clocks.
- R6: A status byte whose bit 0 (write in progress) is 1 causes another 0x05 frame. A status byte whose bit 0 is 0 moves on to the confirming read. Bit 1 (write-enable latch) has no effect.
- R7: If MAX_POLLS status bytes in a row all have bit 0 set, the run ends with err=1 and err_code=1 (timeout), and no confirming read is issued.
- R8: If the confirming read has bit 7 set, the run ends with err=1 and err_code=2. Otherwise it ends with done=1 and err_code=0.
- R9: A start pulse while busy is ignored. A start pulse while idle begins a new run and clears done, err and err_code.
- R10: done and err are never high together, and neither is high while busy. Both hold their value until the next run begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the sequence again |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last run finished with quad mode confirmed |
| err | output | 1 | Last run failed |
| err_code | output | 2 | 0 none, 1 poll timeout, 2 verify failed |

## Verification
The bench builds the block with DIV=3, so the serial clock has an uneven duty cycle (two clocks low, one high), and the bit spacing is checked against a divisor that does not split evenly. MAX_POLLS is set to 4, so a flash model that stays busy for 3, 4 or more polls reaches both the last successful poll and the timeout within a short run. The model can also ignore the register write, which exercises both outcomes of a confirming read: a stuck bit 7 that was already set, and one that was already clear.

// File: rtl/qe_pkg.sv
package qe_pkg;

  localparam logic [7:0] OP_CFG_RD  = 8'h65;
  localparam logic [7:0] OP_CFG_WR  = 8'h61;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_STAT_RD = 8'h05;

  localparam logic [1:0] EC_NONE    = 2'd0;
  localparam logic [1:0] EC_TIMEOUT = 2'd1;
  localparam logic [1:0] EC_VERIFY  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_RDCFG, S_WREN, S_WRCFG, S_POLL, S_VERIFY
  } step_t;

  // Quad enable is active-low on bit 7: clear it, keep the rest.
  function automatic logic [7:0] quad_cleared(input logic [7:0] v);
    return v & 8'h7F;
  endfunction

  // Status bit 0 reports a write still in progress.
  function automatic logic write_pending(input logic [7:0] s);
    return s[0];
  endfunction

  function automatic logic quad_live(input logic [7:0] v);
    return ~v[7];
  endfunction

endpackage

// File: rtl/qe_spi_frame.sv
module qe_spi_frame #(
  parameter int DIV = 4,
  parameter int GAP = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        len16,
  input  logic [15:0] tx_word,
  input  logic        miso,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  output logic [7:0]  rx_byte,
  output logic        fin
);
  localparam int LOW_T = DIV - DIV / 2;
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int GW = $clog2(GAP + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] CNT_RISE = CW'(LOW_T);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP - 1);

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_t;

  eng_t          st;
  logic [CW-1:0] cnt;
  logic [3:0]    bcnt;
  logic [3:0]    blast;
  logic [15:0]   sh;
  logic [GW-1:0] gcnt;

  assign cs_n = (st != E_SHIFT);
  assign sclk = (st == E_SHIFT) && (cnt >= CNT_RISE);
  assign mosi = (st == E_SHIFT) && sh[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      cnt     <= '0;
      bcnt    <= '0;
      blast   <= '0;
      sh      <= '0;
      gcnt    <= '0;
      rx_byte <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        E_IDLE: if (go) begin
          sh    <= tx_word;
          blast <= len16 ? 4'd15 : 4'd7;
          bcnt  <= '0;
          cnt   <= '0;
          st    <= E_SHIFT;
        end
        E_SHIFT: begin
          if (cnt == CNT_RISE) rx_byte <= {rx_byte[6:0], miso};
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            sh  <= {sh[14:0], 1'b0};
            if (bcnt == blast) begin
              st   <= E_GAP;
              gcnt <= '0;
            end else begin
              bcnt <= bcnt + 4'd1;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        E_GAP: begin
          gcnt <= gcnt + GW'(1);
          if (gcnt == GAP_LAST) begin
            st  <= E_IDLE;
            fin <= 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/qe_step_ctrl.sv
module qe_step_ctrl
  import qe_pkg::*;
#(
  parameter int MAX_POLLS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        fin,
  input  logic [7:0]  rx_byte,
  output logic        go,
  output logic        len16,
  output logic [15:0] tx_word,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [1:0]  err_code
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  step_t         step;
  logic          waiting;
  logic          pend;
  logic [7:0]    cfg;
  logic [PW-1:0] polls;

  assign busy = (step != S_IDLE);

  always_comb begin
    len16   = 1'b1;
    tx_word = {OP_CFG_RD, 8'h00};
    unique case (step)
      S_WREN:  begin tx_word = {OP_WREN, 8'h00}; len16 = 1'b0; end
      S_WRCFG: tx_word = {OP_CFG_WR, quad_cleared(cfg)};
      S_POLL:  tx_word = {OP_STAT_RD, 8'h00};
      default: tx_word = {OP_CFG_RD, 8'h00};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= S_IDLE;
      waiting  <= 1'b0;
      pend     <= 1'b1;
      cfg      <= '0;
      polls    <= '0;
      go       <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= EC_NONE;
    end else begin
      go <= 1'b0;
      if (step == S_IDLE) begin
        if (start || pend) begin
          pend     <= 1'b0;
          done     <= 1'b0;
          err      <= 1'b0;
          err_code <= EC_NONE;
          waiting  <= 1'b0;
          step     <= S_RDCFG;
        end
      end else if (!waiting) begin
        go      <= 1'b1;
        waiting <= 1'b1;
      end else if (fin) begin
        waiting <= 1'b0;
        unique case (step)
          S_RDCFG: begin
            cfg  <= rx_byte;
            step <= S_WREN;
          end
          S_WREN:  step <= S_WRCFG;
          S_WRCFG: begin
            polls <= '0;
            step  <= S_POLL;
          end
          S_POLL: begin
            polls <= polls + PW'(1);
            if (!write_pending(rx_byte)) begin
              step <= S_VERIFY;
            end else if (polls == POLL_LAST) begin
              err      <= 1'b1;
              err_code <= EC_TIMEOUT;
              step     <= S_IDLE;
            end
          end
          S_VERIFY: begin
            if (quad_live(rx_byte)) begin
              done <= 1'b1;
            end else begin
              err      <= 1'b1;
              err_code <= EC_VERIFY;
            end
            step <= S_IDLE;
          end
          default: step <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_quad_enabler.sv
module flash_quad_enabler #(
  parameter int DIV       = 4,
  parameter int GAP       = 2,
  parameter int MAX_POLLS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       cs_n,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [1:0] err_code
);
  // Hand-off between sequencing and shifting, named for the checker.
  logic        frame_go;
  logic        frame_fin;
  logic        frame_len16;
  logic [15:0] frame_tx;
  logic [7:0]  frame_rx;

  qe_step_ctrl #(.MAX_POLLS(MAX_POLLS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fin      (frame_fin),
    .rx_byte  (frame_rx),
    .go       (frame_go),
    .len16    (frame_len16),
    .tx_word  (frame_tx),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .err_code (err_code)
  );

  qe_spi_frame #(.DIV(DIV), .GAP(GAP)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (frame_go),
    .len16   (frame_len16),
    .tx_word (frame_tx),
    .miso    (miso),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .mosi    (mosi),
    .rx_byte (frame_rx),
    .fin     (frame_fin)
  );

endmodule

// File: rtl/qe_checker.sv
module qe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code,
  input logic       frame_go,
  input logic       frame_fin
);
  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n); // R1
  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R4
  AST_CS_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n); // R5
  AST_GO_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |-> cs_n); // R5
  AST_FIN_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fin |-> cs_n); // R5
  AST_CODE_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0) == err); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> busy); // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R10
  AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !err)); // R10
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10
endmodule

bind flash_quad_enabler qe_checker u_qe_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .err_code  (err_code),
  .frame_go  (frame_go),
  .frame_fin (frame_fin)
);

// File: tb/test_flash_quad_enabler.sv
module test_flash_quad_enabler;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam int GAP = 2;
  localparam int MAXP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic miso = 1'b0;
  logic cs_n, sclk, mosi, busy, done, err;
  logic [1:0] err_code;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  flash_quad_enabler #(.DIV(DIV), .GAP(GAP), .MAX_POLLS(MAXP)) i_flash_quad_enabler (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso), .busy(busy), .done(done), .err(err),
    .err_code(err_code)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Flash model state and monitors.
  logic [7:0] m_cfg = 8'h00;
  logic [7:0] m_op, m_din, m_out, m_wr;
  int m_bits = 0;
  int m_wip = 0;
  int m_busy_polls = 0;
  bit m_stuck = 0;
  int m_wrn = 0;
  logic [7:0] logop [0:31];
  int logn = 0;
  time t_rise = 0, t_sclk = 0;
  bit have_rise = 0, have_sclk = 0;
  int gap_bad = 0, per_bad = 0, edge_bad = 0;

  always @(negedge cs_n) begin
    if (have_rise && ($time - t_rise) < 2 * CLK_PERIOD) gap_bad++;
    if (sclk) edge_bad++;
    m_bits = 0; m_op = 8'h00; m_din = 8'h00; miso = 1'b0; have_sclk = 0;
  end

  always @(posedge cs_n) begin
    if (sclk) edge_bad++;
    t_rise = $time; have_rise = 1;
    if (m_bits >= 8 && logn < 32) begin logop[logn] = m_op; logn++; end
    if (m_op == 8'h61 && m_bits == 16) begin
      m_wr = m_din; m_wrn++;
      if (!m_stuck) m_cfg = m_din;
      m_wip = m_busy_polls;
    end
    if (m_op == 8'h05 && m_bits == 16 && m_wip > 0) m_wip--;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      if (have_sclk && ($time - t_sclk) != DIV * CLK_PERIOD) per_bad++;
      t_sclk = $time; have_sclk = 1;
      if (m_bits < 8) m_op = {m_op[6:0], mosi};
      else m_din = {m_din[6:0], mosi};
      m_bits++;
    end
  end

  always @(negedge sclk) begin
    if (!cs_n && m_bits >= 8 && m_bits < 16) begin
      if (m_bits == 8) begin
        if (m_op == 8'h65) m_out = m_cfg;
        else if (m_op == 8'h05) m_out = {6'b0, 1'b1, (m_wip > 0)}; // bit 1 always set (R6)
        else m_out = 8'h00;
      end
      miso = m_out[7 - (m_bits - 8)];
    end
  end

  // Expected values, derived from the requirements.
  function automatic logic [7:0] exp_written(input logic [7:0] v);
    return {1'b0, v[6:0]};
  endfunction
  function automatic int exp_polls(input int bp);
    return (bp >= MAXP) ? MAXP : bp + 1;
  endfunction
  function automatic logic [1:0] exp_code(input int bp, input bit stuck, input logic [7:0] v);
    if (bp >= MAXP) return 2'd1;
    if (stuck && v[7]) return 2'd2;
    return 2'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_end(output bit hung);
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    hung = (n >= 20000);
  endtask

  task automatic verify_run(input logic [7:0] cfg0, input int bp, input bit stuck);
    bit hung;
    int np, nexp;
    bit ok;
    logic [1:0] ec;
    wait_end(hung);
    chk(!hung, "R2", "run finished", hung, 0);
    ec = exp_code(bp, stuck, cfg0);
    np = exp_polls(bp);
    nexp = 3 + np + ((ec == 2'd1) ? 0 : 1);
    ok = (logn == nexp);
    for (int i = 0; i < logn && i < 32; i++) begin
      logic [7:0] e;
      if (i == 0) e = 8'h65;
      else if (i == 1) e = 8'h06;
      else if (i == 2) e = 8'h61;
      else if (i < 3 + np) e = 8'h05;
      else e = 8'h65;
      if (logop[i] != e) ok = 0;
    end
    chk(ok, (ec == 2'd1) ? "R7" : "R2", "frame order/count", logn, nexp);
    chk(m_wr == exp_written(cfg0), "R3", "written byte", m_wr, exp_written(cfg0));
    chk(err_code == ec, (ec == 2'd1) ? "R7" : "R8", "err_code", err_code, ec);
    chk(err == (ec != 2'd0), "R8", "err", err, ec != 2'd0);
    chk(done == (ec == 2'd0), "R8", "done", done, ec == 2'd0);
    chk(!busy, "R10", "busy low", busy, 0);
    chk(per_bad == 0 && edge_bad == 0, "R4", "sclk timing", per_bad + edge_bad, 0);
    chk(gap_bad == 0, "R5", "cs gap", gap_bad, 0);
  endtask

  task automatic launch(input logic [7:0] cfg0, input int bp, input bit stuck, input bit mid_start);
    m_cfg = cfg0; m_busy_polls = bp; m_stuck = stuck; logn = 0; m_wr = 8'hxx;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done && !err && err_code == 0, "R9", "run begins, result cleared", {busy, done, err}, 3'b100);
    if (mid_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0; // R9 ignored while busy
    end
    verify_run(cfg0, bp, stuck);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_cfg = 8'hC5; m_busy_polls = 2; m_stuck = 0;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && !err && err_code == 0, "R1", "reset state",
        {cs_n, sclk, busy, done, err, err_code}, 7'b1000000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy, "R1", "auto start after reset", busy, 1);
    verify_run(8'hC5, 2, 0);
    // Directed corners
    launch(8'hFF, 0, 0, 0);          // R6 immediate ready
    launch(8'h80, MAXP - 1, 0, 0);   // R6 last allowed poll succeeds
    launch(8'h3C, MAXP, 0, 0);       // R7 timeout at limit
    launch(8'hA5, 2, 1, 0);          // R8 stuck bit 7 -> verify failure
    launch(8'h5A, 1, 1, 0);          // R8 stuck but already clear -> done
    launch(8'hF0, 1, 0, 1);          // R9 start while busy ignored
    // Random mix
    for (int k = 0; k < 10; k++) begin
      logic [7:0] c;
      int bp;
      bit st;
      c = 8'($urandom);
      bp = $urandom_range(0, MAXP + 1);
      st = ($urandom_range(0, 3) == 0);
      launch(c, bp, st, 0);
    end
    // R10 results hold while idle
    repeat (20) @(negedge clk);
    chk(!busy && cs_n && logn != 0, "R10", "idle holds, no stray frame", busy, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule